// File: doc/BRIEF.md
# Dual-Mode Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with a small register interface of the kind a classic 8-bit controller core expects. Software writes a control byte to choose between a ten-bit frame (start, eight data bits, stop) and an eleven-bit frame (start, eight data bits, a ninth bit, stop). It also enables reception and sets the ninth transmit bit. Writing a byte to the data register sends a frame. Received bytes appear in a receive buffer. Two sticky flags in the control byte report a finished transmission and a new reception, and either flag can raise an interrupt output.

Bit timing comes from an external `baud_tick` strobe that pulses at sixteen times the bit rate. The receiver synchronises the line and confirms a start bit in the middle of the bit. It then samples each later bit at its centre. An accept filter can drop frames: when the multiprocessor-enable bit is set, a frame is kept only if its qualifying bit is 1. In the ten-bit mode that bit is the stop bit, and in the eleven-bit mode it is the ninth bit. This lets a node on a shared line ignore traffic that is not an address frame.

Control byte layout: bit 7 selects the eleven-bit mode, bit 5 is multiprocessor-enable, bit 4 is receive-enable, bit 3 is the ninth transmit bit, bit 2 is the received qualifying bit, bit 1 is the transmit flag, and bit 0 is the receive flag. Bit 6 is plain storage.

Top module: `serial_port`

## Requirements
- R1: After reset, `txd` is 1, `ctrl_q` is 0x00, `data_q` is 0x00 and `irq` is 0.
- R2: A write with `reg_sel`=1 starts a frame. `txd` goes low for one bit, carries the eight data bits LSB first, and then goes high for the stop bit. Each bit lasts 16 `baud_tick` pulses. In this mode control bit 7 is 0.
- R3: With control bit 7 set, the frame has eleven bits. After the eighth data bit, `txd` carries the value of control bit 3, followed by a high stop bit.
- R4: Control bit 1 becomes 1 when the stop bit starts on `txd`. It is still 0 during the last bit before the stop bit.
- R5: A data write while a frame is being sent has no effect on `txd`. When the frame ends, `txd` returns high and stays high.
- R6: A frame arriving on `rxd` while control bit 4 is 0 leaves `data_q` and `ctrl_q` unchanged.
- R7: In the ten-bit mode, a frame is loaded only if control bit 0 is 0 and either control bit 5 is 0 or the received stop bit is 1. On load, the byte goes to `data_q`, the stop bit goes to control bit 2, and control bit 0 is set.
- R8: In the eleven-bit mode, the received ninth bit goes to control bit 2 and the stop bit is ignored. With control bit 5 set, a frame is loaded only if its ninth bit is 1.
- R9: When the load condition fails, for example on overrun with control bit 0 already set, `data_q`, control bit 2 and control bit 0 all keep their values.
- R10: A low pulse on `rxd` that ends before the middle of a bit is not taken as a start bit. The receiver goes back to idle and the next frame is received normally.
- R11: `irq` is 1 exactly when `int_en` is 1 and control bit 1 or control bit 0 is 1.
- R12: Control bits 1 and 0 are cleared only by a control write (`reg_sel`=0). If hardware sets a flag in the same cycle as a control write, the hardware set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = control, 1 = data (starts transmission) |
| reg_wdata | input | 8 | Write data |
| int_en | input | 1 | Interrupt enable |
| rxd | input | 1 | Serial receive line |
| data_q | output | 8 | Receive buffer |
| ctrl_q | output | 8 | Control and status byte |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial transmit line |

## Verification
If the transmit bit counter or the latched frame length is wrong, the fault shows on `txd` within one bit time. It appears as a misplaced ninth bit, a missing stop bit, or a transmit flag that rises a bit early or late. If the receiver's phase or sample index is wrong, a shifted byte lands in `data_q` or control bit 2 takes the wrong value, and this is visible as soon as the frame completes. If the accept logic is wrong, a filtered or overrun frame that should have been dropped changes `data_q` or the flags. A broken start-bit check shows up as a spurious or missing load right after a short glitch.

// File: rtl/sport_pkg.sv
// Package: shared constants and types for the serial port.
// Assumes the control byte is eight bits wide, with the bit positions fixed below.
package sport_pkg;
    localparam int CTRL_W   = 8;
    localparam int CB_MODE9 = 7;
    localparam int CB_MPEN  = 5;
    localparam int CB_RXEN  = 4;
    localparam int CB_TB8   = 3;
    localparam int CB_RB8   = 2;
    localparam int CB_TI    = 1;
    localparam int CB_RI    = 0;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/sport_tx.sv
// Transmitter: serialises a start bit, DW data bits LSB first, an optional ninth
// bit and a stop bit, with each bit held for OVS ticks. Gives a one-cycle pulse
// when the stop bit starts. Assumes the tick is a one-cycle strobe. A start request
// while busy is ignored.
module sport_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          mode9,
    input  logic          bit9,
    input  logic [DW-1:0] din,
    output logic          txd,
    output logic          stop_begin
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW + 3);
    localparam logic [CW-1:0] TICK_LAST = CW'(OVS - 1);

    logic [CW-1:0] tick_q;
    logic [BW-1:0] bit_q, last_q;
    logic [DW+1:0] sh_q;
    logic          busy_q, txd_q, stop_q;

    // Frame sequencer: load on start, then shift one bit every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            bit_q  <= '0;
            last_q <= '0;
            sh_q   <= '1;
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
            stop_q <= 1'b0;
        end else begin
            stop_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                txd_q  <= 1'b0;
                sh_q   <= {1'b1, (mode9 ? bit9 : 1'b1), din};
                bit_q  <= '0;
                last_q <= mode9 ? BW'(DW + 2) : BW'(DW + 1);
                tick_q <= '0;
            end else if (busy_q && tick) begin
                if (tick_q == TICK_LAST) begin
                    tick_q <= '0;
                    if (bit_q == last_q) begin
                        busy_q <= 1'b0;
                        txd_q  <= 1'b1;
                    end else begin
                        txd_q  <= sh_q[0];
                        sh_q   <= {1'b1, sh_q[DW+1:1]};
                        bit_q  <= bit_q + 1'b1;
                        stop_q <= ((bit_q + 1'b1) == last_q);
                    end
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end
        end
    end

    assign txd        = txd_q;
    assign stop_begin = stop_q;

    // The line idles high whenever no frame is in flight.
    assert_idle_line_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> txd_q);

    // The stop-begin pulse coincides with a high (stop) level on the line.
    assert_flag_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> txd_q);
endmodule

// File: rtl/sport_rx.sv
// Receiver: waits for a low level while enabled, confirms the start bit half a
// bit later, then takes one sample at the centre of each data, ninth and stop
// bit. Gives a one-cycle done pulse, with the fields valid in that cycle.
// Assumes rxd_s is already synchronised to clk.
module sport_rx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd_s,
    input  logic          en,
    input  logic          mode9,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          bit9,
    output logic          stopb
);
    import sport_pkg::*;

    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW + 3);
    localparam logic [CW-1:0] TICK_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] TICK_HALF = CW'(OVS / 2 - 1);

    rx_state_t     state_q;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] idx_q;
    logic [DW+1:0] sh_q;
    logic          mode_q, done_q;

    wire [BW-1:0] idx_last = mode_q ? BW'(DW + 1) : BW'(DW);

    // Frame receiver FSM: detect, confirm, then sample the centre of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            mode_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (en && tick && !rxd_s) begin
                        state_q <= RX_START;
                        cnt_q   <= '0;
                        mode_q  <= mode9;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt_q == TICK_HALF) begin
                            cnt_q   <= '0;
                            idx_q   <= '0;
                            state_q <= rxd_s ? RX_IDLE : RX_BITS;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                RX_BITS: begin
                    if (tick) begin
                        if (cnt_q == TICK_LAST) begin
                            cnt_q <= '0;
                            sh_q  <= {rxd_s, sh_q[DW+1:1]};
                            if (idx_q == idx_last) begin
                                done_q  <= 1'b1;
                                state_q <= RX_IDLE;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign done  = done_q;
    assign data  = mode_q ? sh_q[DW-1:0] : sh_q[DW:1];
    assign bit9  = sh_q[DW];
    assign stopb = sh_q[DW+1];
endmodule

// File: rtl/serial_port.sv
// Top level: control/status byte, receive buffer, input synchroniser and the
// accept filter that connects the receiver to the buffer. Assumes DATA_W >= 8.
// A hardware flag set takes priority over a control write in the same cycle.
module serial_port #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              int_en,
    input  logic              rxd,
    output logic [DATA_W-1:0] data_q,
    output logic [7:0]        ctrl_q,
    output logic              irq,
    output logic              txd
);
    import sport_pkg::*;

    logic [CTRL_W-1:0]      ctrl_r;
    logic [DATA_W-1:0]      rbuf_r;
    logic [SYNC_STAGES-1:0] sync_r;
    logic                   rx_done, rx_bit9, rx_stop, stop_begin;
    logic [DATA_W-1:0]      rx_data;

    wire ctrl_wr    = reg_wr && !reg_sel;
    wire data_wr    = reg_wr && reg_sel;
    wire rxd_s      = sync_r[SYNC_STAGES-1];
    wire accept_bit = ctrl_r[CB_MODE9] ? rx_bit9 : rx_stop;
    wire rx_load    = rx_done && !ctrl_r[CB_RI] && (!ctrl_r[CB_MPEN] || accept_bit);

    // Two-or-more flop synchroniser for the asynchronous receive line.
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (!rst_n) sync_r <= '1;
                else        sync_r <= rxd;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (!rst_n) sync_r <= '1;
                else        sync_r <= {sync_r[SYNC_STAGES-2:0], rxd};
            end
        end
    endgenerate

    sport_tx #(.DW(DATA_W), .OVS(OVS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .start      (data_wr),
        .mode9      (ctrl_r[CB_MODE9]),
        .bit9       (ctrl_r[CB_TB8]),
        .din        (reg_wdata),
        .txd        (txd),
        .stop_begin (stop_begin)
    );

    sport_rx #(.DW(DATA_W), .OVS(OVS)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (baud_tick),
        .rxd_s (rxd_s),
        .en    (ctrl_r[CB_RXEN]),
        .mode9 (ctrl_r[CB_MODE9]),
        .done  (rx_done),
        .data  (rx_data),
        .bit9  (rx_bit9),
        .stopb (rx_stop)
    );

    // Control byte and receive buffer: software write first, hardware sets override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_r <= '0;
            rbuf_r <= '0;
        end else begin
            if (ctrl_wr) ctrl_r <= reg_wdata[CTRL_W-1:0];
            if (stop_begin) ctrl_r[CB_TI] <= 1'b1;
            if (rx_load) begin
                ctrl_r[CB_RI]  <= 1'b1;
                ctrl_r[CB_RB8] <= accept_bit;
                rbuf_r         <= rx_data;
            end
        end
    end

    assign ctrl_q = ctrl_r;
    assign data_q = rbuf_r;
    assign irq    = int_en && (ctrl_r[CB_TI] || ctrl_r[CB_RI]);

    // Flags only fall after a control write.
    assert_ri_clear_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_r[CB_RI]) |-> $past(ctrl_wr));
    assert_ti_clear_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_r[CB_TI]) |-> $past(ctrl_wr));

    // A pending receive flag with no software write freezes the buffer.
    assert_overrun_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_r[CB_RI]) && !$past(ctrl_wr)) |-> $stable(rbuf_r));
endmodule

// File: tb/tb_serial_port.sv
module tb_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       int_en = 1'b1;
    logic       rxd = 1'b1;
    logic [7:0] data_q, ctrl_q;
    logic       irq, txd;

    int total = 0;
    int fails = 0;
    logic [1:0] div_q = 2'd0;
    logic [7:0] exp_buf;

    always #2 clk = ~clk;

    // Tick every fourth clock: one bit = 64 clocks.
    always @(posedge clk) begin
        div_q     <= div_q + 2'd1;
        baud_tick <= (div_q == 2'd3);
    end

    serial_port dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .int_en(int_en), .rxd(rxd),
        .data_q(data_q), .ctrl_q(ctrl_q), .irq(irq), .txd(txd)
    );

    // Vector: {mode9, mp_en, ri_pre, ninth, stop, data[7:0]}
    localparam int NV = 9;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h81},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h77},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11},
        {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hE7},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send_rx(input logic m9, input logic [7:0] d, input logic b9, input logic stp);
        @(negedge clk);
        rxd = 1'b0;
        repeat (64) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (64) @(negedge clk);
        end
        if (m9) begin
            rxd = b9;
            repeat (64) @(negedge clk);
        end
        rxd = stp;
        repeat (48) @(negedge clk);
        rxd = 1'b1;
        repeat (80) @(negedge clk);
    endtask

    task automatic tx_frame(input logic m9, input logic b8, input logic [7:0] d, input bit poke);
        int n;
        logic e;
        wr(1'b0, {m9, 3'b000, b8, 3'b000});
        wr(1'b1, d);
        n = m9 ? 11 : 10;
        repeat (30) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            if (b == 0) e = 1'b0;
            else if (b <= 8) e = d[b-1];
            else if (b == 9 && m9) e = b8;
            else e = 1'b1;
            if (b == n - 1) chk(ctrl_q[1] == 1'b1, "R4 flag at stop", ctrl_q[1], 1);
            if (b == n - 2) chk(ctrl_q[1] == 1'b0, "R4 flag before stop", ctrl_q[1], 0);
            chk(txd == e, m9 ? "R3 nine-bit tx" : "R2 eight-bit tx", txd, e);
            if (poke && b == 2) begin
                wr(1'b1, ~d);
                repeat (62) @(negedge clk);
            end else begin
                repeat (64) @(negedge clk);
            end
        end
        if (poke) begin
            for (int k = 0; k < 5; k++) begin
                chk(txd == 1'b1, "R5 idle after ignored write", txd, 1);
                repeat (40) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(ctrl_q == 8'h00, "R1 ctrl", ctrl_q, 0);
        chk(data_q == 8'h00, "R1 data", data_q, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        exp_buf = 8'h00;

        // Transmit: both modes, both ninth-bit values, and a write while busy.
        tx_frame(1'b0, 1'b0, 8'hB4, 1'b0);
        tx_frame(1'b1, 1'b1, 8'h6D, 1'b0);
        tx_frame(1'b1, 1'b0, 8'hF1, 1'b0);
        tx_frame(1'b0, 1'b0, 8'h2E, 1'b1);
        // R11 with the transmit flag
        int_en = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R11 masked", irq, 0);
        int_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R11 tx flag", irq, 1);

        // Receive vectors (R7, R8, R9)
        for (int v = 0; v < NV; v++) begin
            logic m9, mp, rp, b9, sp, ld, q;
            logic [7:0] d;
            {m9, mp, rp, b9, sp, d} = VEC[v];
            q  = m9 ? b9 : sp;
            ld = !rp && (!mp || q);
            wr(1'b0, {m9, 1'b0, mp, 1'b1, 3'b000, rp});
            send_rx(m9, d, b9, sp);
            if (ld) exp_buf = d;
            chk(data_q == exp_buf, m9 ? "R8 buffer" : (rp ? "R9 buffer" : "R7 buffer"), data_q, exp_buf);
            chk(ctrl_q[0] == (ld | rp), m9 ? "R8 rx flag" : (rp ? "R9 rx flag" : "R7 rx flag"), ctrl_q[0], ld | rp);
            chk(ctrl_q[2] == (ld & q), m9 ? "R8 ninth" : (rp ? "R9 stop" : "R7 stop"), ctrl_q[2], ld & q);
        end

        // R6: receiver disabled
        wr(1'b0, 8'h00);
        send_rx(1'b0, 8'h99, 1'b0, 1'b1);
        chk(data_q == exp_buf, "R6 buffer", data_q, exp_buf);
        chk(ctrl_q == 8'h00, "R6 ctrl", ctrl_q, 0);

        // R10: short glitch, then a real frame
        wr(1'b0, 8'h10);
        @(negedge clk);
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (100) @(negedge clk);
        chk(ctrl_q[0] == 1'b0, "R10 glitch ignored", ctrl_q[0], 0);
        send_rx(1'b0, 8'h4B, 1'b0, 1'b1);
        chk(data_q == 8'h4B, "R10 frame after glitch", data_q, 8'h4B);
        chk(irq == 1'b1, "R11 rx flag", irq, 1);

        // R12: flags persist until a control write clears them
        repeat (200) @(negedge clk);
        chk(ctrl_q[0] == 1'b1, "R12 flag sticky", ctrl_q[0], 1);
        wr(1'b0, 8'h00);
        @(negedge clk);
        chk(ctrl_q[0] == 1'b0, "R12 flag cleared", ctrl_q[0], 0);
        chk(irq == 1'b0, "R11 no flags", irq, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule